// File: doc/BRIEF.md
# Fetch Address Patch and Breakpoint Unit

This block sits on the instruction-fetch address path between a processor core and its read-only code memory. It holds a bank of programmable word comparators. Each one is either a hardware breakpoint or a patch slot. As a breakpoint it raises a flag toward the debug logic when its word is fetched. As a patch slot it redirects fetches of its word to one entry in a patch table, which can sit in writable memory or in another flash area.

Software or a debugger sets the unit up through a single write port, one 32-bit register per index. The fetch side presents an address with a valid strobe. In the same cycle the unit returns the address to use, a remap-hit flag and a breakpoint flag. Redirection only takes place for addresses in the code region, which is the lowest 512 MB of the address space. Breakpoints work at any address.

Top module: `fetch_patch_unit`

## Requirements
- R1: There are eight comparators. After a synchronous reset, every register reads as cleared: the global enable, each comparator enable, mode and match word, and the table base. No fetch then raises either flag, and out_addr equals fetch_addr.
- R2: The control register sits at index 0, with the global enable in bit 0. While this bit is 0, no comparator has any effect.
- R3: Comparator n is configured at index 2+n. Bit 0 is its enable. Bit 1 is its mode: 0 means remap and 1 means breakpoint. Bits [31:2] hold the match word address. The comparator matches any fetch whose bits [31:2] equal that word, whatever the byte offset.
- R4: When the winning comparator is in breakpoint mode, bkpt_hit is high, remap_hit is low and out_addr equals fetch_addr. This holds at any address, including addresses outside the code region.
- R5: When the winning comparator n is in remap mode and the fetch lies in the code region (bits [31:29] zero), remap_hit is high, bkpt_hit is low and out_addr = table base + 4*n, modulo 2^32. Bits [1:0] of out_addr are taken from fetch_addr.
- R6: A remap-mode comparator never matches a fetch outside the code region. Such a fetch passes through unchanged unless a breakpoint comparator matches it.
- R7: The table base register sits at index 1 and keeps bits [31:2] of the written value. Bits [1:0] of the written value are ignored.
- R8: When more than one enabled comparator matches a fetch, the lowest-numbered one decides the outcome.
- R9: While fetch_valid is low, both flags are low and out_addr equals fetch_addr.
- R10: Translation is combinational: the outputs follow fetch_addr in the same cycle. A register write takes effect from the clock edge that captures it, and not before.
- R11: Writes to indices 10 to 15 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index |
| cfg_wdata | input | 32 | Register write data |
| fetch_valid | input | 1 | Fetch address valid |
| fetch_addr | input | 32 | Fetch byte address |
| out_addr | output | 32 | Possibly redirected fetch address |
| remap_hit | output | 1 | Fetch was redirected to the patch table |
| bkpt_hit | output | 1 | Fetch matched a breakpoint comparator |

## Verification
The bench runs every comparator through all four byte offsets in remap mode and checks the neighbouring word. A design that compared byte addresses would miss offsets, and one that redirected to base + n would hit the wrong slot. For every pair of comparators, the bench places both on the same word with opposite modes, which exposes any priority inversion. It probes the code-region boundary at 0x1FFFFFFC and 0x20000000: a design that decoded the region with the wrong width would redirect fetches it should pass through. Further tests cover low base bits, unused register indices and the cycle in which a write becomes visible. These catch aliasing decodes and write data that is used before it is captured.

// File: rtl/fpatch_pkg.sv
package fpatch_pkg;

  typedef enum logic {
    MODE_REMAP = 1'b0,
    MODE_BKPT  = 1'b1
  } cmp_mode_e;

  // register index layout
  localparam int CTRL_IDX  = 0;
  localparam int BASE_IDX  = 1;
  localparam int CMP_IDX0  = 2;

  // bit positions inside the registers
  localparam int GEN_BIT   = 0;
  localparam int CEN_BIT   = 1 - 1;
  localparam int CMODE_BIT = 1;

  // byte offset bits within a 32-bit word
  localparam int WORD_LSB  = 2;

endpackage

// File: rtl/fpatch_regs.sv
module fpatch_regs
  import fpatch_pkg::*;
#(
  parameter int NUM_CMP = 8,
  parameter int ADDR_W  = 32,
  parameter int REG_AW  = 4,
  localparam int WA_W   = ADDR_W - WORD_LSB
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cfg_we,
  input  logic [REG_AW-1:0]              cfg_addr,
  input  logic [ADDR_W-1:0]              cfg_wdata,
  output logic                           glob_en,
  output logic [WA_W-1:0]                tbl_base,
  output logic [NUM_CMP-1:0]             cmp_en,
  output logic [NUM_CMP-1:0]             cmp_mode,
  output logic [NUM_CMP-1:0][WA_W-1:0]   cmp_match
);

  logic ctrl_sel, base_sel;

  assign ctrl_sel = cfg_we && (cfg_addr == REG_AW'(CTRL_IDX));
  assign base_sel = cfg_we && (cfg_addr == REG_AW'(BASE_IDX));

  always_ff @(posedge clk) begin
    if (rst) begin
      glob_en <= 1'b0;
    end else if (ctrl_sel) begin
      glob_en <= cfg_wdata[GEN_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tbl_base <= '0;
    end else if (base_sel) begin
      tbl_base <= cfg_wdata[ADDR_W-1:WORD_LSB];
    end
  end

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp_reg
    logic sel;
    assign sel = cfg_we && (cfg_addr == REG_AW'(CMP_IDX0 + g));

    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_en[g]    <= 1'b0;
        cmp_mode[g]  <= MODE_REMAP;
        cmp_match[g] <= '0;
      end else if (sel) begin
        cmp_en[g]    <= cfg_wdata[CEN_BIT];
        cmp_mode[g]  <= cfg_wdata[CMODE_BIT];
        cmp_match[g] <= cfg_wdata[ADDR_W-1:WORD_LSB];
      end
    end
  end

  // R1: every enable is cleared right after reset
  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!glob_en && cmp_en == '0 && tbl_base == '0));

  // R10: a control write shows from the next cycle on
  a_r10_ctrl_write_lands: assert property (@(posedge clk) disable iff (rst)
    ctrl_sel |=> (glob_en == $past(cfg_wdata[GEN_BIT])));

  // R7: low bits of the base write are dropped
  a_r7_base_write_lands: assert property (@(posedge clk) disable iff (rst)
    base_sel |=> (tbl_base == $past(cfg_wdata[ADDR_W-1:WORD_LSB])));

  // R11: unused indices leave the base and control alone
  a_r11_unused_idx: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr >= REG_AW'(CMP_IDX0 + NUM_CMP)) |=>
      ($stable(glob_en) && $stable(tbl_base) && $stable(cmp_en)));

endmodule

// File: rtl/fpatch_cmp.sv
module fpatch_cmp
  import fpatch_pkg::*;
#(
  parameter int WA_W = 30
) (
  input  logic            glob_en,
  input  logic            en,
  input  logic            mode,
  input  logic [WA_W-1:0] match_word,
  input  logic [WA_W-1:0] fetch_word,
  input  logic            in_code,
  output logic            hit
);

  logic word_eq, region_ok;

  assign word_eq   = (match_word == fetch_word);
  // breakpoints fire anywhere, remaps only inside the code region
  assign region_ok = (mode == MODE_BKPT) || in_code;
  assign hit       = glob_en && en && word_eq && region_ok;

endmodule

// File: rtl/fpatch_prio.sv
module fpatch_prio #(
  parameter int NUM_REQ = 8,
  localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic [NUM_REQ-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);

  always_comb begin
    idx = '0;
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign any = |req;

  // R8: the chosen request is live and nothing below it is
  always_comb begin
    if (any) begin
      a_r8_lowest_wins: assert (req[idx] &&
        ((req & ((NUM_REQ'(1) << idx) - NUM_REQ'(1))) == '0));
    end
  end

endmodule

// File: rtl/fetch_patch_unit.sv
module fetch_patch_unit
  import fpatch_pkg::*;
#(
  parameter int NUM_CMP   = 8,
  parameter int ADDR_W    = 32,
  parameter int CODE_BITS = 3,
  localparam int REG_AW   = $clog2(NUM_CMP + CMP_IDX0),
  localparam int WA_W     = ADDR_W - WORD_LSB,
  localparam int IDX_W    = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic [ADDR_W-1:0] out_addr,
  output logic              remap_hit,
  output logic              bkpt_hit
);

  logic                         glob_en;
  logic [WA_W-1:0]              tbl_base;
  logic [NUM_CMP-1:0]           cmp_en;
  logic [NUM_CMP-1:0]           cmp_mode;
  logic [NUM_CMP-1:0][WA_W-1:0] cmp_match;
  logic [NUM_CMP-1:0]           cmp_hit;
  logic                         any_hit;
  logic [IDX_W-1:0]             win_idx;
  logic                         win_mode;
  logic                         in_code;
  logic [WA_W-1:0]              fetch_word;
  logic [WA_W-1:0]              slot_word;

  fpatch_regs #(
    .NUM_CMP (NUM_CMP),
    .ADDR_W  (ADDR_W),
    .REG_AW  (REG_AW)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .glob_en   (glob_en),
    .tbl_base  (tbl_base),
    .cmp_en    (cmp_en),
    .cmp_mode  (cmp_mode),
    .cmp_match (cmp_match)
  );

  assign fetch_word = fetch_addr[ADDR_W-1:WORD_LSB];
  assign in_code    = (fetch_addr[ADDR_W-1 -: CODE_BITS] == '0);

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    fpatch_cmp #(.WA_W(WA_W)) u_cmp (
      .glob_en    (glob_en),
      .en         (cmp_en[g]),
      .mode       (cmp_mode[g]),
      .match_word (cmp_match[g]),
      .fetch_word (fetch_word),
      .in_code    (in_code),
      .hit        (cmp_hit[g])
    );
  end

  fpatch_prio #(.NUM_REQ(NUM_CMP)) u_prio (
    .req (cmp_hit),
    .any (any_hit),
    .idx (win_idx)
  );

  assign win_mode  = cmp_mode[win_idx];
  assign slot_word = tbl_base + WA_W'(win_idx);

  always_comb begin
    remap_hit = fetch_valid && any_hit && (win_mode == MODE_REMAP);
    bkpt_hit  = fetch_valid && any_hit && (win_mode == MODE_BKPT);
    out_addr  = remap_hit ? {slot_word, fetch_addr[WORD_LSB-1:0]} : fetch_addr;
  end

  // R9: an idle fetch port sees no flags and an untouched address
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |-> (!remap_hit && !bkpt_hit && out_addr == fetch_addr));

  // R4: a breakpoint leaves the address alone and excludes remap
  a_r4_bkpt_passthru: assert property (@(posedge clk) disable iff (rst)
    bkpt_hit |-> (!remap_hit && out_addr == fetch_addr));

  // R6: redirection only for code-region fetches
  a_r6_remap_in_code: assert property (@(posedge clk) disable iff (rst)
    remap_hit |-> (fetch_addr[ADDR_W-1 -: CODE_BITS] == '0));

  // R5: byte offset inside the word survives redirection
  a_r5_offset_kept: assert property (@(posedge clk) disable iff (rst)
    remap_hit |-> (out_addr[WORD_LSB-1:0] == fetch_addr[WORD_LSB-1:0]));

  // R2: with the global enable low, nothing fires
  a_r2_global_gate: assert property (@(posedge clk) disable iff (rst)
    !glob_en |-> (!remap_hit && !bkpt_hit));

endmodule

// File: tb/sim_fetch_patch_unit.sv
module sim_fetch_patch_unit;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        fetch_valid;
  logic [31:0] fetch_addr;
  logic [31:0] out_addr;
  logic        remap_hit;
  logic        bkpt_hit;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench-side picture of the programmed state
  bit        m_glob;
  bit [29:0] m_base;
  bit        m_en   [N];
  bit        m_mode [N];
  bit [29:0] m_match[N];

  always #10 clk = ~clk;

  fetch_patch_unit u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .out_addr(out_addr), .remap_hit(remap_hit), .bkpt_hit(bkpt_hit)
  );

  function automatic void model(input bit [31:0] a, input bit v,
                                output bit [31:0] o, output bit r, output bit b);
    bit found = 0;
    o = a; r = 0; b = 0;
    if (v && m_glob) begin
      for (int n = 0; n < N; n++) begin
        if (!found && m_en[n] && m_match[n] == a[31:2] &&
            (m_mode[n] || a[31:29] == 3'b000)) begin
          found = 1;
          if (m_mode[n]) b = 1;
          else begin
            r = 1;
            o = {m_base + 30'(n), a[1:0]};
          end
        end
      end
    end
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input int idx, input bit [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = idx[3:0]; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (idx == 0) m_glob = d[0];
    else if (idx == 1) m_base = d[31:2];
    else if (idx >= 2 && idx < 2 + N) begin
      m_en[idx-2] = d[0]; m_mode[idx-2] = d[1]; m_match[idx-2] = d[31:2];
    end
  endtask

  task automatic probe(input bit [31:0] a, input bit v, input string tag);
    bit [31:0] eo; bit er, eb;
    @(negedge clk);
    fetch_addr = a; fetch_valid = v;
    #2;
    model(a, v, eo, er, eb);
    chk(out_addr === eo && remap_hit === er && bkpt_hit === eb, tag,
        "{remap,bkpt,addr}", {remap_hit, bkpt_hit, out_addr}, {er, eb, eo});
  endtask

  task automatic clear_cmps();
    for (int n = 0; n < N; n++) wr(2 + n, 32'h0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    rst = 1; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
    fetch_valid = 0; fetch_addr = '0;
    m_glob = 0; m_base = '0;
    for (int n = 0; n < N; n++) begin m_en[n] = 0; m_mode[n] = 0; m_match[n] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1: cleared after reset
    probe(32'h0000_0000, 1, "R1");
    probe(32'h0000_0104, 1, "R1");
    probe(32'h8000_0000, 1, "R1");

    // R2: comparator armed but global enable low
    wr(2, 32'h0000_0101);
    wr(3, 32'h0000_0203);
    probe(32'h0000_0100, 1, "R2");
    probe(32'h0000_0200, 1, "R2");
    wr(0, 32'h1);
    probe(32'h0000_0100, 1, "R2");
    probe(32'h0000_0200, 1, "R2");
    clear_cmps();

    // R5 / R3: every comparator in remap mode, all byte offsets, neighbours
    wr(1, 32'h2000_4000);
    for (int n = 0; n < N; n++) begin
      bit [31:0] a = 32'h0000_1000 + 32'(n) * 32'h40;
      wr(2 + n, a | 32'h1);
      for (int b = 0; b < 4; b++) probe(a + 32'(b), 1, "R5");
      probe(a + 32'h4, 1, "R3");
      probe(a - 32'h4, 1, "R3");
      wr(2 + n, 32'h0);
    end
    // all at once, then the expected slot computed directly
    for (int n = 0; n < N; n++) wr(2 + n, (32'h0000_1000 + 32'(n) * 32'h40) | 32'h1);
    for (int n = 0; n < N; n++) begin
      @(negedge clk);
      fetch_addr = 32'h0000_1002 + 32'(n) * 32'h40; fetch_valid = 1;
      #2;
      chk(out_addr === 32'h2000_4002 + 32'(n) * 4 && remap_hit === 1, "R5",
          "slot address", {remap_hit, bkpt_hit, out_addr},
          {2'b10, 32'h2000_4002 + 32'(n) * 4});
    end
    // R9: valid low with live comparators
    for (int n = 0; n < N; n++) probe(32'h0000_1000 + 32'(n) * 32'h40, 0, "R9");
    clear_cmps();

    // R7: low base bits ignored, base wraps modulo 2^32
    wr(1, 32'h1000_0003);
    wr(4, 32'h0000_0800 | 32'h1);
    probe(32'h0000_0801, 1, "R7");
    wr(1, 32'hFFFF_FFFE);
    probe(32'h0000_0803, 1, "R7");
    wr(4, 32'h0);

    // R4: breakpoint in every comparator, high region too
    for (int n = 0; n < N; n++) begin
      bit [31:0] a = 32'h6000_0000 + 32'(n) * 8;
      wr(2 + n, a | 32'h3);
      probe(a + 32'h1, 1, "R4");
      probe(a + 32'h4, 1, "R4");
      wr(2 + n, 32'h0000_0400 | 32'h3);
      probe(32'h0000_0402, 1, "R4");
      wr(2 + n, 32'h0);
    end

    // R6: remap outside the code region, and the region boundary
    wr(1, 32'h2000_8000);
    wr(2, 32'h2000_0000 | 32'h1);
    probe(32'h2000_0000, 1, "R6");
    wr(2, 32'h1FFF_FFFC | 32'h1);
    probe(32'h1FFF_FFFD, 1, "R6");
    wr(2, 32'hE000_0010 | 32'h1);
    wr(3, 32'hE000_0010 | 32'h3);
    probe(32'hE000_0010, 1, "R6");
    clear_cmps();

    // R8: every pair on the same word, both mode orders
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        wr(2 + i, 32'h0000_2000 | 32'h3);
        wr(2 + j, 32'h0000_2000 | 32'h1);
        probe(32'h0000_2001, 1, "R8");
        wr(2 + i, 32'h0000_2000 | 32'h1);
        wr(2 + j, 32'h0000_2000 | 32'h3);
        probe(32'h0000_2002, 1, "R8");
        wr(2 + i, 32'h0); wr(2 + j, 32'h0);
      end
    end

    // R11: unused indices write nothing
    wr(5, 32'h0000_3000 | 32'h1);
    for (int k = 10; k < 16; k++) begin
      @(negedge clk);
      cfg_we = 1; cfg_addr = 4'(k); cfg_wdata = 32'h0000_5003;
      @(negedge clk);
      cfg_we = 0;
    end
    probe(32'h0000_3000, 1, "R11");
    probe(32'h0000_5000, 1, "R11");
    for (int n = 0; n < N; n++) probe(32'h0000_5000 + 32'(n), 1, "R11");

    // R10: write not visible before its edge, visible after
    @(negedge clk);
    fetch_addr = 32'h0000_6004; fetch_valid = 1;
    cfg_we = 1; cfg_addr = 4'd9; cfg_wdata = 32'h0000_6004 | 32'h3;
    #2;
    chk(bkpt_hit === 0, "R10", "before edge", {remap_hit, bkpt_hit, out_addr},
        {2'b00, 32'h0000_6004});
    @(posedge clk); #2;
    cfg_we = 0;
    chk(bkpt_hit === 1 && out_addr === 32'h0000_6004, "R10", "after edge",
        {remap_hit, bkpt_hit, out_addr}, {2'b01, 32'h0000_6004});
    m_en[7] = 1; m_mode[7] = 1; m_match[7] = 30'h0000_6004 >> 2;

    // R2: global disable silences live comparators
    wr(0, 32'h0);
    probe(32'h0000_6004, 1, "R2");
    probe(32'h0000_3000, 1, "R2");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule